// File: doc/BRIEF.md
# Event Ring Producer with Interrupt Arming

This block is the device side of a circular event ring. Event records arrive on a valid/ready input. Each accepted record goes into the next slot of an internal power-of-two ring, and its ownership bit is written in the same cycle. Software never sees a separate valid flag. Instead, an entry counts as present when its ownership bit matches the wrap parity of the index used to reach it. That parity flips every time the producer index passes the end of the ring.

The consumer reports its progress through doorbell writes. Each doorbell carries a consumer index and a queue number. The word offset of the write decides one of two things:

- whether the doorbell only moves the consumer index, or
- whether it also re-arms the interrupt.

A small arming state machine raises a single-cycle interrupt pulse when a record lands in the armed state, and then stays quiet until it is re-armed. An optional always-armed build raises a pulse for every record. If the ring ever fills completely, a sticky overflow flag is set and input acceptance stops. A registered read port lets the consumer side fetch any slot.

Top module: `evq_producer`

## Requirements
- R1: After reset:
  - the producer index is 0 and every slot's ownership bit reads 1;
  - `irq` and `overflow` are 0 and `evt_ready` is 1;
  - `arm_state` is 0xA (fired), or 0xB in the always-armed build.
- R2: Each accepted record (`evt_valid` and `evt_ready` high at a rising edge) is stored in slot `prod_idx[DEPTH_LOG2-1:0]`, and `prod_idx` then increments by one. The read port returns the slot named on `rd_slot` one edge later.
- R3: A record's ownership bit is written equal to `prod_idx[DEPTH_LOG2]` at the time it is written, so it is 0 on the first lap of the ring and 1 on the second.
- R4: The doorbell word carries the consumer index in bits [23:0] and the queue number in bits [31:24]. The offset decides what it does:
  - offset 0 sets the consumer index and arms the queue;
  - offset 2 sets the consumer index only;
  - offsets 1 and 3 have no effect.
- R5: A doorbell whose queue number differs from `QUEUE_ID` has no effect.
- R6: When a record is accepted in the armed state (0x9), `irq` is high for exactly the following cycle and the state becomes fired (0xA).
- R7: In the fired state, accepted records raise no interrupt.
- R8: An arming doorbell moves the state to armed (0x9) when no unconsumed records remain after it. Otherwise it moves the state to fired (0xA) and pulses `irq` in the following cycle.
- R9: With `ALWAYS_ARMED` set, `arm_state` stays 0xB and every accepted record pulses `irq` in the following cycle. Doorbells still move the consumer index.
- R10: When the producer index minus the consumer index (modulo 2^24) equals the ring depth:
  - `evt_ready` is low;
  - `overflow` rises one edge later;
  - `overflow` then stays high with `evt_ready` low until reset, even after the consumer catches up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Event record offered |
| evt_data | input | EVT_W | Event record payload |
| evt_ready | output | 1 | Ring can accept a record |
| db_valid | input | 1 | Doorbell write strobe |
| db_off | input | 2 | Doorbell word offset |
| db_data | input | 32 | Doorbell word: queue number [31:24], consumer index [23:0] |
| rd_slot | input | DEPTH_LOG2 | Slot to read |
| rd_data | output | EVT_W | Registered payload of the slot read |
| rd_owner | output | 1 | Registered ownership bit of the slot read |
| irq | output | 1 | One-cycle interrupt pulse |
| overflow | output | 1 | Sticky ring-full flag |
| arm_state | output | 4 | Arming state: 0x9 armed, 0xA fired, 0xB always armed |
| prod_idx | output | 24 | Producer index |

## Verification
Every result that follows an accepted record or a doorbell is due at the first rising edge after it: the interrupt pulse, the state change, the new producer index and the change in `evt_ready`. The overflow flag appears one edge later still, and read data arrives one edge after the slot is presented. The bench drives all inputs at falling edges. It compares the outputs at the next falling edge against a bench model that is stepped once per cycle, so each check falls in the cycle its result is due. A second instance built always-armed receives the same stimulus and is checked in the same cycles.

// File: rtl/eqp_pkg.sv
package eqp_pkg;
  localparam int IDX_W = 24;
  localparam int QID_W = 8;
  localparam int DB_W  = IDX_W + QID_W;

  typedef enum logic [3:0] {
    ARM_ARMED  = 4'h9,
    ARM_FIRED  = 4'hA,
    ARM_ALWAYS = 4'hB
  } arm_state_e;

  localparam logic [1:0] DB_OFF_ARM = 2'd0;
  localparam logic [1:0] DB_OFF_UPD = 2'd2;
endpackage

// File: rtl/eqp_db_decode.sv
module eqp_db_decode import eqp_pkg::*; #(
  parameter logic [QID_W-1:0] QUEUE_ID = 8'h05
) (
  input  logic             db_valid,
  input  logic [1:0]       db_off,
  input  logic [DB_W-1:0]  db_data,
  output logic             ci_upd,
  output logic             arm_req,
  output logic [IDX_W-1:0] ci_val
);
  logic qid_hit;

  assign qid_hit = db_data[DB_W-1 -: QID_W] == QUEUE_ID;
  assign ci_val  = db_data[IDX_W-1:0];

  always_comb begin
    ci_upd  = 1'b0;
    arm_req = 1'b0;
    if (db_valid && qid_hit) begin
      if (db_off == DB_OFF_ARM) begin
        ci_upd  = 1'b1;
        arm_req = 1'b1;
      end else if (db_off == DB_OFF_UPD) begin
        ci_upd  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/eqp_ring.sv
module eqp_ring #(
  parameter int EVT_W      = 32,
  parameter int DEPTH_LOG2 = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [DEPTH_LOG2-1:0] wr_slot,
  input  logic                  wr_parity,
  input  logic [EVT_W-1:0]      wr_data,
  input  logic [DEPTH_LOG2-1:0] rd_slot,
  output logic [EVT_W-1:0]      rd_data,
  output logic                  rd_owner
);
  localparam int DEPTH = 1 << DEPTH_LOG2;

  logic [EVT_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0] own_q;

  // payload array: no reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_slot] <= wr_data;
    rd_data <= mem[rd_slot];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q    <= '1;
      rd_owner <= 1'b1;
    end else begin
      if (wr_en) own_q[wr_slot] <= wr_parity;
      rd_owner <= own_q[rd_slot];
    end
  end

  AST_OWNER_PARITY: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> own_q[$past(wr_slot)] == $past(wr_parity)); // R3
endmodule

// File: rtl/eqp_arm_ctl.sv
module eqp_arm_ctl import eqp_pkg::*; #(
  parameter bit ALWAYS_ARMED = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       arm_req,
  input  logic       pend_nxt,
  output logic [3:0] arm_state,
  output logic       irq
);
  localparam arm_state_e INIT_ST = ALWAYS_ARMED ? ARM_ALWAYS : ARM_FIRED;

  arm_state_e st_q, st_nxt;
  logic       fire;

  generate
    if (ALWAYS_ARMED) begin : g_always
      always_comb begin
        st_nxt = ARM_ALWAYS;
        fire   = wr_en;
      end
    end else begin : g_gated
      always_comb begin
        st_nxt = st_q;
        fire   = 1'b0;
        if (arm_req) begin
          if (pend_nxt) begin
            st_nxt = ARM_FIRED;
            fire   = 1'b1;
          end else begin
            st_nxt = ARM_ARMED;
          end
        end else if (wr_en && st_q == ARM_ARMED) begin
          st_nxt = ARM_FIRED;
          fire   = 1'b1;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= INIT_ST;
      irq  <= 1'b0;
    end else begin
      st_q <= st_nxt;
      irq  <= fire;
    end
  end

  assign arm_state = st_q;

  AST_IRQ_LEAVES_ARMED: assert property (@(posedge clk) disable iff (rst)
    irq |-> st_q != ARM_ARMED); // R6
  AST_FIRED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st_q == ARM_FIRED && !arm_req) |=> !irq); // R7
  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    st_q inside {ARM_ARMED, ARM_FIRED, ARM_ALWAYS}); // R8
endmodule

// File: rtl/evq_producer.sv
module evq_producer import eqp_pkg::*; #(
  parameter int               EVT_W        = 32,
  parameter int               DEPTH_LOG2   = 3,
  parameter logic [QID_W-1:0] QUEUE_ID     = 8'h05,
  parameter bit               ALWAYS_ARMED = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  evt_valid,
  input  logic [EVT_W-1:0]      evt_data,
  output logic                  evt_ready,
  input  logic                  db_valid,
  input  logic [1:0]            db_off,
  input  logic [DB_W-1:0]       db_data,
  input  logic [DEPTH_LOG2-1:0] rd_slot,
  output logic [EVT_W-1:0]      rd_data,
  output logic                  rd_owner,
  output logic                  irq,
  output logic                  overflow,
  output logic [3:0]            arm_state,
  output logic [IDX_W-1:0]      prod_idx
);
  localparam int               DEPTH    = 1 << DEPTH_LOG2;
  localparam logic [IDX_W-1:0] FULL_OCC = IDX_W'(DEPTH);

  logic [IDX_W-1:0] prod_q, cons_q, occ, prod_nxt, cons_nxt, ci_val;
  logic             ovf_q, wr_en, ci_upd, arm_req, pend_nxt;

  assign occ       = prod_q - cons_q;
  assign evt_ready = (occ != FULL_OCC) && !ovf_q;
  assign wr_en     = evt_valid && evt_ready;
  assign prod_nxt  = prod_q + IDX_W'(wr_en);
  assign cons_nxt  = ci_upd ? ci_val : cons_q;
  assign pend_nxt  = prod_nxt != cons_nxt;

  eqp_db_decode #(.QUEUE_ID(QUEUE_ID)) db_i (
    .db_valid(db_valid), .db_off(db_off), .db_data(db_data),
    .ci_upd(ci_upd), .arm_req(arm_req), .ci_val(ci_val)
  );

  eqp_ring #(.EVT_W(EVT_W), .DEPTH_LOG2(DEPTH_LOG2)) ring_i (
    .clk(clk), .rst(rst), .wr_en(wr_en),
    .wr_slot(prod_q[DEPTH_LOG2-1:0]), .wr_parity(prod_q[DEPTH_LOG2]),
    .wr_data(evt_data), .rd_slot(rd_slot),
    .rd_data(rd_data), .rd_owner(rd_owner)
  );

  eqp_arm_ctl #(.ALWAYS_ARMED(ALWAYS_ARMED)) arm_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .arm_req(arm_req),
    .pend_nxt(pend_nxt), .arm_state(arm_state), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q <= '0;
      cons_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      prod_q <= prod_nxt;
      cons_q <= cons_nxt;
      ovf_q  <= ovf_q | (occ == FULL_OCC);
    end
  end

  assign prod_idx = prod_q;
  assign overflow = ovf_q;

  AST_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> occ != FULL_OCC); // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf_q |=> ovf_q && !evt_ready); // R10
  AST_PROD_STEP: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> prod_q == $past(prod_q) + 1'b1); // R2
endmodule

// File: tb/evq_producer_tb_top.sv
module evq_producer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;
  localparam logic [7:0] QID = 8'h05;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic evt_valid = 1'b0;
  logic [31:0] evt_data = '0;
  logic db_valid = 1'b0;
  logic [1:0] db_off = '0;
  logic [31:0] db_data = '0;
  logic [AW-1:0] rd_slot = '0;
  logic evt_ready, rd_owner, irq, overflow;
  logic [31:0] rd_data;
  logic [3:0] arm_state;
  logic [23:0] prod_idx;
  logic aa_ready, aa_owner, aa_irq, aa_ovf;
  logic [31:0] aa_data;
  logic [3:0] aa_state;
  logic [23:0] aa_prod;

  int n_chk = 0;
  int n_err = 0;

  // bench model
  logic [23:0] m_prod, m_cons;
  logic [3:0]  m_state;
  logic        m_irq, m_ovf;
  logic [31:0] m_mem [DEPTH];
  logic        m_own [DEPTH];
  logic        m_has [DEPTH];
  logic        m_wr;

  always #(CLK_PERIOD/2) clk = ~clk;

  evq_producer #(.EVT_W(32), .DEPTH_LOG2(AW), .QUEUE_ID(QID), .ALWAYS_ARMED(1'b0)) dut_i (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_data(evt_data), .evt_ready(evt_ready),
    .db_valid(db_valid), .db_off(db_off), .db_data(db_data), .rd_slot(rd_slot),
    .rd_data(rd_data), .rd_owner(rd_owner), .irq(irq), .overflow(overflow),
    .arm_state(arm_state), .prod_idx(prod_idx));

  evq_producer #(.EVT_W(32), .DEPTH_LOG2(AW), .QUEUE_ID(QID), .ALWAYS_ARMED(1'b1)) dut_aa_i (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_data(evt_data), .evt_ready(aa_ready),
    .db_valid(db_valid), .db_off(db_off), .db_data(db_data), .rd_slot(rd_slot),
    .rd_data(aa_data), .rd_owner(aa_owner), .irq(aa_irq), .overflow(aa_ovf),
    .arm_state(aa_state), .prod_idx(aa_prod));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic m_ready();
    return ((m_prod - m_cons) != 24'(DEPTH)) && !m_ovf;
  endfunction

  task automatic model_reset();
    m_prod = '0; m_cons = '0; m_state = 4'hA; m_irq = 1'b0; m_ovf = 1'b0; m_wr = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      m_own[i] = 1'b1; m_has[i] = 1'b0; m_mem[i] = '0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; evt_valid = 1'b0; db_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  // one cycle: drive at a falling edge, advance the model, compare at the next falling edge
  task automatic step(input bit v, input logic [31:0] d, input bit dv,
                      input logic [1:0] off, input logic [31:0] dd);
    logic hit, arm;
    logic [23:0] np, nc;
    evt_valid = v; evt_data = d; db_valid = dv; db_off = off; db_data = dd;
    m_wr = v && m_ready();
    hit  = dv && dd[31:24] == QID && (off == 2'd0 || off == 2'd2);
    arm  = hit && off == 2'd0;
    np   = m_prod + 24'(m_wr);
    nc   = hit ? dd[23:0] : m_cons;
    m_ovf = m_ovf | ((m_prod - m_cons) == 24'(DEPTH));
    m_irq = 1'b0;
    if (arm) begin
      if (np != nc) begin m_state = 4'hA; m_irq = 1'b1; end
      else m_state = 4'h9;
    end else if (m_wr && m_state == 4'h9) begin
      m_state = 4'hA; m_irq = 1'b1;
    end
    if (m_wr) begin
      m_mem[m_prod[AW-1:0]] = d;
      m_own[m_prod[AW-1:0]] = m_prod[AW];
      m_has[m_prod[AW-1:0]] = 1'b1;
    end
    m_prod = np; m_cons = nc;
    @(negedge clk);
    evt_valid = 1'b0; db_valid = 1'b0;
    chk(irq == m_irq, "R6 R7 R8", "irq", 32'(irq), 32'(m_irq));
    chk(arm_state == m_state, "R8", "arm_state", 32'(arm_state), 32'(m_state));
    chk(prod_idx == m_prod, "R2", "prod_idx", 32'(prod_idx), 32'(m_prod));
    chk(evt_ready == m_ready(), "R10", "evt_ready", 32'(evt_ready), 32'(m_ready()));
    chk(overflow == m_ovf, "R10", "overflow", 32'(overflow), 32'(m_ovf));
    chk(aa_irq == m_wr, "R9", "always-armed irq", 32'(aa_irq), 32'(m_wr));
    chk(aa_state == 4'hB, "R9", "always-armed state", 32'(aa_state), 32'hB);
  endtask

  task automatic wr(input logic [31:0] d);
    step(1'b1, d, 1'b0, 2'd0, 32'd0);
  endtask

  task automatic db(input logic [1:0] off, input logic [7:0] q, input logic [23:0] ci);
    step(1'b0, 32'd0, 1'b1, off, {q, ci});
  endtask

  task automatic rd_chk(input int s, input string req);
    rd_slot = AW'(s);
    @(negedge clk);
    chk(rd_owner == m_own[s], req, $sformatf("owner slot %0d", s), 32'(rd_owner), 32'(m_own[s]));
    if (m_has[s])
      chk(rd_data == m_mem[s], req, $sformatf("data slot %0d", s), rd_data, m_mem[s]);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // R1 reset state
    chk(arm_state == 4'hA, "R1", "reset state", 32'(arm_state), 32'hA);
    chk(aa_state == 4'hB, "R1", "reset state always", 32'(aa_state), 32'hB);
    chk(evt_ready && !overflow && !irq, "R1", "ready/ovf/irq", {29'd0, evt_ready, overflow, irq}, 32'h4);
    chk(prod_idx == 0, "R1", "prod_idx", 32'(prod_idx), 0);
    for (int s = 0; s < DEPTH; s++) rd_chk(s, "R1");

    // R7 writes in the fired state stay quiet
    wr(32'hA0);
    // R8 arming with nothing pending -> armed
    db(2'd0, QID, m_prod);
    chk(arm_state == 4'h9, "R8", "armed when empty", 32'(arm_state), 32'h9);
    // R6 write while armed fires once
    wr(32'hA1);
    chk(irq == 1'b1, "R6", "irq on armed write", 32'(irq), 1);
    wr(32'hA2);
    chk(irq == 1'b0, "R7", "no irq when fired", 32'(irq), 0);
    // R8 arming with pending entries fires at once
    db(2'd0, QID, m_prod - 24'd1);
    chk(irq == 1'b1 && arm_state == 4'hA, "R8", "fire on pending arm", {27'd0, irq, arm_state}, 32'h1A);
    // R4 offset 2 updates only, no arming
    db(2'd2, QID, m_prod);
    chk(arm_state == 4'hA && !irq, "R4", "offset 2 no arm", 32'(arm_state), 32'hA);
    wr(32'hA3);
    chk(irq == 1'b0, "R4", "still unarmed after offset 2", 32'(irq), 0);
    // R5 wrong queue number ignored
    db(2'd0, 8'h06, m_prod);
    chk(arm_state == 4'hA && !irq, "R5", "foreign queue ignored", 32'(arm_state), 32'hA);
    // R4 offset 1 ignored
    db(2'd1, QID, m_prod);
    chk(arm_state == 4'hA && !irq, "R4", "offset 1 ignored", 32'(arm_state), 32'hA);

    // R2 R3 wrap parity
    do_reset();
    for (int i = 0; i < DEPTH; i++) begin
      wr(32'hB000 + 32'(i));
      db(2'd2, QID, m_prod);
    end
    for (int s = 0; s < DEPTH; s++) rd_chk(s, "R3");
    chk(m_own[0] == 1'b0, "R3", "first lap parity", 32'(m_own[0]), 0);
    for (int i = 0; i < 3; i++) begin
      wr(32'hC000 + 32'(i));
      db(2'd2, QID, m_prod);
    end
    for (int s = 0; s < DEPTH; s++) rd_chk(s, "R2");
    chk(rd_owner == 1'b0, "R3", "untouched slot keeps lap-1 parity", 32'(rd_owner), 0);
    rd_chk(1, "R3");
    chk(rd_owner == 1'b1 && rd_data == 32'hC001, "R3", "second lap slot1", {rd_data[30:0], rd_owner}, {31'h0000_C001, 1'b1});

    // R10 overflow
    do_reset();
    for (int i = 0; i < DEPTH; i++) wr(32'hD000 + 32'(i));
    chk(!evt_ready, "R10", "ready low when full", 32'(evt_ready), 0);
    wr(32'hDEAD);
    chk(overflow == 1'b1 && prod_idx == 24'(DEPTH), "R10", "overflow set, no write", {overflow, 7'd0, prod_idx}, {1'b1, 7'd0, 24'(DEPTH)});
    db(2'd2, QID, m_prod);
    wr(32'hBEEF);
    chk(overflow && !evt_ready, "R10", "overflow sticky", {30'd0, overflow, evt_ready}, 32'h2);

    // random traffic, R9 checked in every step
    do_reset();
    for (int n = 0; n < 3000; n++) begin
      int r;
      logic [23:0] occ, ci;
      logic [1:0] off;
      logic [7:0] q;
      r = int'($urandom_range(0, 99));
      occ = m_prod - m_cons;
      ci = m_prod - 24'($urandom_range(0, int'(occ > 24'(DEPTH) ? 24'(DEPTH) : occ)));
      off = ($urandom_range(0, 9) < 8) ? (($urandom_range(0, 1) == 0) ? 2'd0 : 2'd2) : 2'($urandom_range(0, 3));
      q = ($urandom_range(0, 9) == 0) ? 8'h33 : QID;
      if (occ >= 24'(DEPTH - 1)) begin ci = m_prod; q = QID; off = 2'd2; end
      step(r < 55, $urandom, r >= 40, off, {q, ci});
    end
    for (int s = 0; s < DEPTH; s++) rd_chk(s, "R2");

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule